// File: doc/BRIEF.md
# Flag Offset Register Sequencer

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against: an empty offset and a full offset, each as wide as the FIFO address. Each offset is held as an 8-bit low byte and a narrow high part of `log2(DEPTH) - 8` bits. Software reaches the four pieces through a single 9-bit data port. No address is given. A write sequencer steps through the pieces in a fixed wrapping order: empty low, empty high, full low, full high, then back to empty low. A separate read sequencer walks the same order and returns each piece on a registered readback output.

Access is possible only while the FIFO runs in programmable-offset mode (`prog_mode` high, the mode latched at FIFO reset) and `load_sel` is high. In that state a write strobe stores `din` into the piece under the write sequencer. A read strobe places the piece under the read sequencer on `rd_data`. Each sequencer keeps its position when `load_sel` drops, so a later session carries on where the last one stopped. Both pointers are small state machines with the states SEQ_E_LO, SEQ_E_HI, SEQ_F_LO and SEQ_F_HI. Their only transition is "advance", taken on an accepted access: SEQ_E_LO to SEQ_E_HI, SEQ_E_HI to SEQ_F_LO, SEQ_F_LO to SEQ_F_HI, and SEQ_F_HI back to SEQ_E_LO. Without an accepted access a pointer stays in its state.

Top module: `flag_offset_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, both offsets equal 7 and `rd_data` is 0. Both sequencers start at the empty low byte.
- R2: With `prog_mode`, `load_sel` and `wr_en` high, successive clock edges store `din[7:0]` into the empty low byte, then the empty high part, then the full low byte, then the full high part. `empty_ofs` is {empty high, empty low} and `full_ofs` is {full high, full low}.
- R3: The fifth accepted write after the empty low byte wraps back to the empty low byte.
- R4: With `load_sel` high and `wr_en` low, neither offset changes.
- R5: With `load_sel` low, writes have no effect. When loading resumes, it starts at the piece after the last one written.
- R6: With `prog_mode` and `load_sel` high, `rd_en` high and `wr_en` low, each clock edge loads `rd_data` with the next piece in the same order as R2. A low byte appears on bits [7:0]. A high part appears zero-extended. Bit 8 reads 0.
- R7: When a write and a read are requested in the same cycle, only the write is performed. `rd_data` holds its value and the read sequencer does not advance.
- R8: With `prog_mode` low (two-write-enable mode), no access is accepted. The offsets, `rd_data` and both sequencers are unchanged.
- R9: `din` bits above the implemented high-part width are dropped on a high-part write, and those bits read back as zero.
- R10: The read and write sequencers advance independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_sel | input | 1 | High selects offset access instead of FIFO data access |
| wr_en | input | 1 | Write strobe, active high |
| rd_en | input | 1 | Combined read strobe, active high |
| prog_mode | input | 1 | High when the FIFO was configured at reset for programmable offsets |
| din | input | 9 | Data input carrying offset pieces |
| empty_ofs | output | log2(DEPTH) | Current empty offset |
| full_ofs | output | log2(DEPTH) | Current full offset |
| rd_data | output | 9 | Registered readback of the offset pieces |

## Verification
The assertions expect every control input to carry a known value on each clock edge after reset. They expect `prog_mode` to be a level, not a pulse. The write-versus-read priority is checked as a rule the block enforces, not as a condition the stimulus has to avoid. The stimulus drives inputs only from defined values a step after the rising edge. In the random phase `prog_mode` is held high most of the time, so that the sequencers walk many wraps. Cycles with both strobes high are generated on purpose to exercise the collision case.

// File: rtl/flag_offset_seq_pkg.sv
package flag_offset_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_E_LO = 2'd0,
        SEQ_E_HI = 2'd1,
        SEQ_F_LO = 2'd2,
        SEQ_F_HI = 2'd3
    } seq_t;

    localparam int PIECE_W = 8;

    function automatic seq_t seq_advance(input seq_t cur);
        seq_t nxt;
        unique case (cur)
            SEQ_E_LO: nxt = SEQ_E_HI;
            SEQ_E_HI: nxt = SEQ_F_LO;
            SEQ_F_LO: nxt = SEQ_F_HI;
            SEQ_F_HI: nxt = SEQ_E_LO;
            default:  nxt = SEQ_E_LO;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr
    import flag_offset_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output seq_t cur
);

    seq_t state_q;
    seq_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_E_LO;
        else        state_q <= state_d;
    end

    // next state: one transition, "advance", on an accepted access
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SEQ_E_LO: state_d = SEQ_E_HI;
                SEQ_E_HI: state_d = SEQ_F_LO;
                SEQ_F_LO: state_d = SEQ_F_HI;
                SEQ_F_HI: state_d = SEQ_E_LO;
                default:  state_d = SEQ_E_LO;
            endcase
        end
    end

    // output
    always_comb cur = state_q;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q == SEQ_F_HI) |=> (cur == SEQ_E_LO)); // R3

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cur)); // R10

endmodule

// File: rtl/ofs_store.sv
module ofs_store
    import flag_offset_seq_pkg::*;
#(
    parameter int AW      = 10,
    parameter int DEF_OFS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  seq_t               wsel,
    input  logic [PIECE_W-1:0] wdata,
    input  seq_t               rsel,
    output logic [PIECE_W-1:0] rbyte,
    output logic [AW-1:0]      empty_ofs,
    output logic [AW-1:0]      full_ofs
);

    localparam int HI_W = AW - PIECE_W;
    localparam logic [AW-1:0]      DEF_FULL = AW'(DEF_OFS);
    localparam logic [PIECE_W-1:0] DEF_LO   = DEF_FULL[PIECE_W-1:0];
    localparam logic [HI_W-1:0]    DEF_HI   = DEF_FULL[AW-1:PIECE_W];

    logic [PIECE_W-1:0] e_lo, f_lo;
    logic [HI_W-1:0]    e_hi, f_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_lo <= DEF_LO;
            e_hi <= DEF_HI;
            f_lo <= DEF_LO;
            f_hi <= DEF_HI;
        end else if (we) begin
            unique case (wsel)
                SEQ_E_LO: e_lo <= wdata;
                SEQ_E_HI: e_hi <= wdata[HI_W-1:0];
                SEQ_F_LO: f_lo <= wdata;
                SEQ_F_HI: f_hi <= wdata[HI_W-1:0];
                default:  e_lo <= wdata;
            endcase
        end
    end

    always_comb begin
        unique case (rsel)
            SEQ_E_LO: rbyte = e_lo;
            SEQ_E_HI: rbyte = {{(PIECE_W-HI_W){1'b0}}, e_hi};
            SEQ_F_LO: rbyte = f_lo;
            SEQ_F_HI: rbyte = {{(PIECE_W-HI_W){1'b0}}, f_hi};
            default:  rbyte = e_lo;
        endcase
    end

    assign empty_ofs = {e_hi, e_lo};
    assign full_ofs  = {f_hi, f_lo};

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(empty_ofs) && $stable(full_ofs))); // R4

    AST_ONE_PIECE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ($countones({e_lo != $past(e_lo), e_hi != $past(e_hi),
                            f_lo != $past(f_lo), f_hi != $past(f_hi)}) <= 1)); // R2

endmodule

// File: rtl/flag_offset_seq.sv
module flag_offset_seq
    import flag_offset_seq_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int DATA_W  = 9,
    parameter int DEF_OFS = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_sel,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     prog_mode,
    input  logic [DATA_W-1:0]        din,
    output logic [$clog2(DEPTH)-1:0] empty_ofs,
    output logic [$clog2(DEPTH)-1:0] full_ofs,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int AW   = $clog2(DEPTH);
    localparam int HI_W = AW - PIECE_W;

    initial begin
        AST_PARAM_RANGE: assert (HI_W >= 1 && HI_W < PIECE_W && DATA_W > PIECE_W); // R9
    end

    logic               acc_ok;
    logic               do_wr;
    logic               do_rd;
    seq_t               wr_pos;
    seq_t               rd_pos;
    logic [PIECE_W-1:0] rbyte;
    logic               unused_top_bits;

    assign acc_ok = prog_mode && load_sel;
    assign do_wr  = acc_ok && wr_en;
    assign do_rd  = acc_ok && rd_en && !wr_en;   // write wins on collision

    assign unused_top_bits = ^din[DATA_W-1:PIECE_W];

    ofs_seq_ptr u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (do_wr),
        .cur   (wr_pos)
    );

    ofs_seq_ptr u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (do_rd),
        .cur   (rd_pos)
    );

    ofs_store #(
        .AW      (AW),
        .DEF_OFS (DEF_OFS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (do_wr),
        .wsel      (wr_pos),
        .wdata     (din[PIECE_W-1:0]),
        .rsel      (rd_pos),
        .rbyte     (rbyte),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (do_rd) rd_data <= DATA_W'(rbyte);
    end

    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(rd_data))); // R8

    AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && load_sel && wr_en && rd_en) |=> $stable(rd_data)); // R7

    AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:HI_W] == '0 || rd_data[DATA_W-1:PIECE_W] == '0); // R6

    AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_sel |=> ($stable(empty_ofs) && $stable(full_ofs))); // R5

endmodule

// File: tb/sim_flag_offset_seq.sv
module sim_flag_offset_seq;

    localparam int DEPTH  = 1024;
    localparam int AW     = $clog2(DEPTH);
    localparam int HI_W   = AW - 8;
    localparam int DATA_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, prog_mode = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [AW-1:0]     empty_ofs, full_ofs;
    logic [DATA_W-1:0] rd_data;

    int total = 0;
    int bad   = 0;

    logic [7:0]        m [4];
    int                wp = 0;
    int                rp = 0;
    logic [DATA_W-1:0] exp_rd = '0;

    always #4 clk = ~clk;

    flag_offset_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEF_OFS(7)) u0 (
        .clk(clk), .rst_n(rst_n), .load_sel(load_sel), .wr_en(wr_en),
        .rd_en(rd_en), .prog_mode(prog_mode), .din(din),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_data(rd_data)
    );

    function automatic logic [AW-1:0] exp_ofs(input logic [7:0] lo, input logic [7:0] hi);
        logic [HI_W-1:0] h;
        h = hi[HI_W-1:0];
        return {h, lo};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "empty_ofs", empty_ofs, exp_ofs(m[0], m[1]));
        check(tag, "full_ofs",  full_ofs,  exp_ofs(m[2], m[3]));
        check(tag, "rd_data",   AW'(rd_data), AW'(exp_rd));
    endtask

    task automatic cyc(input logic ld, input logic we, input logic re,
                       input logic pm, input logic [DATA_W-1:0] d, input string tag);
        load_sel = ld; wr_en = we; rd_en = re; prog_mode = pm; din = d;
        @(posedge clk);
        if (pm && ld && we) begin
            m[wp] = (wp % 2 == 1) ? (d[7:0] & 8'((1 << HI_W) - 1)) : d[7:0];
            wp = (wp + 1) % 4;
        end else if (pm && ld && re) begin
            exp_rd = {1'b0, m[rp]};
            rp = (rp + 1) % 4;
        end
        #1;
        load_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        for (int i = 0; i < 4; i++) m[i] = (i % 2 == 0) ? 8'd7 : 8'd0;
        seed = $urandom(32'd2024);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 / R9: ordered writes, high part masked
        cyc(1, 1, 0, 1, 9'h0A5, "R2");
        cyc(1, 1, 0, 1, 9'h1FF, "R9");
        cyc(1, 1, 0, 1, 9'h13C, "R2");
        cyc(1, 1, 0, 1, 9'h002, "R2");
        // R3: wrap
        cyc(1, 1, 0, 1, 9'h05A, "R3");
        // R4: load selected, no write
        cyc(1, 0, 0, 1, 9'h0FF, "R4");
        cyc(1, 0, 0, 1, 9'h011, "R4");
        // R5: load deselected, then resume at empty high
        cyc(0, 1, 0, 1, 9'h0EE, "R5");
        cyc(1, 1, 0, 1, 9'h001, "R5");
        // R6 / R10: readback starts at empty low regardless of writes
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 1, 9'h000, "R6");
        // R7: collision, write wins
        cyc(1, 1, 1, 1, 9'h077, "R7");
        cyc(1, 0, 1, 1, 9'h000, "R7");
        // R8: two-write-enable mode
        cyc(1, 1, 0, 0, 9'h0C3, "R8");
        cyc(1, 0, 1, 0, 9'h000, "R8");
        cyc(1, 1, 0, 1, 9'h033, "R8");

        // R10: random mix
        for (int i = 0; i < 600; i++) begin
            logic pm, ld, we, re;
            pm = ($urandom % 8) != 0;
            ld = ($urandom % 4) != 0;
            we = $urandom % 2;
            re = $urandom % 2;
            cyc(ld, we, re, pm, DATA_W'($urandom), "R10");
        end

        // R1: reset again mid-run
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) m[i] = (i % 2 == 0) ? 8'd7 : 8'd0;
        wp = 0; rp = 0; exp_rd = '0;
        @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        cyc(1, 0, 1, 1, 9'h000, "R1");
        cyc(1, 1, 0, 1, 9'h044, "R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule